// File: doc/BRIEF.md
# Instruction Decode Stage with Equal-Compare Branch and Flag Write

This block is the decode stage of a five-stage in-order pipeline. It holds the architectural register file, which the writeback stage writes through a dedicated port. Each cycle it reads the two source registers named by the instruction in the fetch/decode latch. When writeback is retiring a value to one of those registers in the same cycle, an external hazard unit raises a per-operand flag, and the stage takes the writeback value instead of the stale file contents. On the next clock edge it registers the instruction word and both operands for the execute stage.

Branches are resolved here, not in execute. One custom I-format opcode compares its two source registers. When they are equal, the stage signals a taken branch to the PC logic with a sign-extended byte offset and writes the constant 1 into the second source register. A stall from the hazard unit turns the outgoing slot into a bubble and suppresses every branch effect.

Top module: `dec_stage`

## Requirements
- R1: After reset the execute-side instruction and both operand registers are zero, `br_taken_o` is low, and every register file entry reads as zero.
- R2: A writeback with `wb_we_i` high to a nonzero address stores `wb_data_i`, and the stored value is visible to decode reads from the following cycle onward.
- R3: Register 0 reads as zero in every case and ignores both writeback and branch writes.
- R4: `a_from_wb_i` makes the A operand equal to `wb_data_i` in place of R[rs], and `b_from_wb_i` does the same for the B operand in place of R[rt]. Without the flag, a same-cycle writeback is not seen.
- R5: When not stalled, one clock edge moves the fetched word into `idex_instr_o`, and the selected A and B operands into `idex_a_o` and `idex_b_o`. Field positions: opcode [31:26], rs [25:21], rt [20:16], immediate [15:0].
- R6: When `stall_i` is high, the next edge loads zero (the nop) into `idex_instr_o`, `idex_a_o` and `idex_b_o`.
- R7: `br_taken_o` is high in the same cycle exactly when the opcode field is 48, `stall_i` is low, and the selected A and B operands are equal, with the bypass flags applied.
- R8: `br_offset_o` carries the immediate sign-extended to the data width while `br_taken_o` is high, and is zero otherwise.
- R9: A taken branch writes the value 1 into R[rt] at the next edge.
- R10: When a taken branch and a writeback target the same register in one cycle, the branch value 1 is kept. When they target different registers, both writes take effect.
- R11: A branch opcode with unequal operands, a non-branch opcode with equal operands, and a stalled branch all leave `br_taken_o` low and R[rt] unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Hold decode and insert a bubble |
| ifid_instr_i | input | 32 | Instruction word from fetch |
| a_from_wb_i | input | 1 | A operand takes the writeback value |
| b_from_wb_i | input | 1 | B operand takes the writeback value |
| wb_we_i | input | 1 | Writeback write enable |
| wb_addr_i | input | 5 | Writeback register address |
| wb_data_i | input | 32 | Writeback value |
| idex_instr_o | output | 32 | Registered instruction for execute |
| idex_a_o | output | 32 | Registered A operand |
| idex_b_o | output | 32 | Registered B operand |
| br_taken_o | output | 1 | Branch resolved taken this cycle |
| br_offset_o | output | 32 | Sign-extended branch offset |

## Verification
The bench uses the default build: 32 registers of 32 bits, with opcode 48 as the branch. At this size the full field layout and every register address, including register 0 and the top entry, can be reached by directed instructions. The bench reads register contents back by sending non-branch instructions through the normal pipeline path. This makes the branch flag write and its precedence over a colliding writeback observable at the ports. The same reads show the difference between bypassed and unbypassed operands in the cycle a write lands.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OPC_LSB = 26;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned RS_LSB  = 21;
  localparam int unsigned RT_LSB  = 16;
  localparam int unsigned IMM_W   = 16;
  localparam logic [INSTR_W-1:0] NOP_WORD = '0;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [4:0]       rs;
    logic [4:0]       rt;
    logic [IMM_W-1:0] imm;
  } ifmt_t;
endpackage

// File: rtl/dec_regfile.sv
module dec_regfile #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NRD   = 2,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wb_we_i,
  input  logic [AW-1:0]   wb_addr_i,
  input  logic [XLEN-1:0] wb_data_i,
  input  logic            fl_we_i,
  input  logic [AW-1:0]   fl_addr_i,
  input  logic [XLEN-1:0] fl_data_i,
  input  logic [AW-1:0]   rd_addr_i [NRD],
  output logic [XLEN-1:0] rd_data_o [NRD]
);
  logic [XLEN-1:0] regs_q [NREG];

  // flag write is younger in program order, so it wins on collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (fl_we_i && fl_addr_i == AW'(i))      regs_q[i] <= fl_data_i;
        else if (wb_we_i && wb_addr_i == AW'(i)) regs_q[i] <= wb_data_i;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = (rd_addr_i[p] == '0) ? '0 : regs_q[rd_addr_i[p]];

    p_zero_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_addr_i[p] == '0 |-> rd_data_o[p] == '0);
  end

  p_wb_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_we_i && wb_addr_i != '0 && !(fl_we_i && fl_addr_i == wb_addr_i))
      |=> regs_q[$past(wb_addr_i)] == $past(wb_data_i));

  p_flag_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_we_i && fl_addr_i != '0) |=> regs_q[$past(fl_addr_i)] == $past(fl_data_i));

  p_r0_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[0] == '0);
endmodule

// File: rtl/dec_opsel.sv
module dec_opsel #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NOP  = 2
) (
  input  logic            byp_i     [NOP],
  input  logic [XLEN-1:0] rf_data_i [NOP],
  input  logic [XLEN-1:0] wb_data_i,
  output logic [XLEN-1:0] op_o      [NOP]
);
  for (genvar p = 0; p < NOP; p++) begin : g_op
    assign op_o[p] = byp_i[p] ? wb_data_i : rf_data_i[p];
  end
endmodule

// File: rtl/dec_branch.sv
module dec_branch
  import dec_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned BR_OPC  = 48,
  parameter int unsigned AW      = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               stall_i,
  input  logic [XLEN-1:0]    op_a_i,
  input  logic [XLEN-1:0]    op_b_i,
  output logic               taken_o,
  output logic [XLEN-1:0]    offset_o,
  output logic               fl_we_o,
  output logic [AW-1:0]      fl_addr_o,
  output logic [XLEN-1:0]    fl_data_o
);
  ifmt_t f;
  logic  is_br;
  logic  [XLEN-1:0] sext;

  assign f       = ifmt_t'(instr_i);
  assign is_br   = (f.opc == OPC_W'(BR_OPC));
  assign sext    = {{(XLEN-IMM_W){f.imm[IMM_W-1]}}, f.imm};
  assign taken_o = is_br && !stall_i && (op_a_i == op_b_i);
  assign offset_o  = taken_o ? sext : '0;
  assign fl_we_o   = taken_o;
  assign fl_addr_o = f.rt[AW-1:0];
  assign fl_data_o = XLEN'(1);

  p_offset_sext_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> offset_o == {{(XLEN-IMM_W){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]});
  p_offset_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> offset_o == '0);
  p_no_take_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !taken_o);
  p_take_needs_eq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (op_a_i == op_b_i) && instr_i[INSTR_W-1 -: OPC_W] == OPC_W'(BR_OPC));
endmodule

// File: rtl/dec_stage.sv
module dec_stage
  import dec_pkg::*;
#(
  parameter int unsigned NREG   = 32,
  parameter int unsigned XLEN   = 32,
  parameter int unsigned BR_OPC = 48,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stall_i,
  input  logic [INSTR_W-1:0] ifid_instr_i,
  input  logic               a_from_wb_i,
  input  logic               b_from_wb_i,
  input  logic               wb_we_i,
  input  logic [AW-1:0]      wb_addr_i,
  input  logic [XLEN-1:0]    wb_data_i,
  output logic [INSTR_W-1:0] idex_instr_o,
  output logic [XLEN-1:0]    idex_a_o,
  output logic [XLEN-1:0]    idex_b_o,
  output logic               br_taken_o,
  output logic [XLEN-1:0]    br_offset_o
);
  logic [AW-1:0]   rd_addr [2];
  logic [XLEN-1:0] rd_data [2];
  logic            byp     [2];
  logic [XLEN-1:0] op      [2];
  logic            fl_we;
  logic [AW-1:0]   fl_addr;
  logic [XLEN-1:0] fl_data;

  assign rd_addr[0] = ifid_instr_i[RS_LSB +: AW];
  assign rd_addr[1] = ifid_instr_i[RT_LSB +: AW];
  assign byp[0]     = a_from_wb_i;
  assign byp[1]     = b_from_wb_i;

  dec_regfile #(.NREG(NREG), .XLEN(XLEN), .NRD(2)) u_rf (
    .clk_i, .rst_ni,
    .wb_we_i, .wb_addr_i, .wb_data_i,
    .fl_we_i(fl_we), .fl_addr_i(fl_addr), .fl_data_i(fl_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  dec_opsel #(.XLEN(XLEN), .NOP(2)) u_opsel (
    .byp_i(byp), .rf_data_i(rd_data), .wb_data_i, .op_o(op)
  );

  dec_branch #(.XLEN(XLEN), .BR_OPC(BR_OPC), .AW(AW)) u_br (
    .clk_i, .rst_ni,
    .instr_i(ifid_instr_i), .stall_i,
    .op_a_i(op[0]), .op_b_i(op[1]),
    .taken_o(br_taken_o), .offset_o(br_offset_o),
    .fl_we_o(fl_we), .fl_addr_o(fl_addr), .fl_data_o(fl_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idex_instr_o <= NOP_WORD;
      idex_a_o     <= '0;
      idex_b_o     <= '0;
    end else if (stall_i) begin
      idex_instr_o <= NOP_WORD;
      idex_a_o     <= '0;
      idex_b_o     <= '0;
    end else begin
      idex_instr_o <= ifid_instr_i;
      idex_a_o     <= op[0];
      idex_b_o     <= op[1];
    end
  end

  p_bubble_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> idex_instr_o == NOP_WORD && idex_a_o == '0 && idex_b_o == '0);
  p_pass_instr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i |=> idex_instr_o == $past(ifid_instr_i));
  p_byp_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && a_from_wb_i) |=> idex_a_o == $past(wb_data_i));
  p_byp_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && b_from_wb_i) |=> idex_b_o == $past(wb_data_i));
endmodule

// File: tb/dec_stage_tb.sv
module dec_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall;
  logic [31:0] instr;
  logic        a_wb, b_wb, wb_we;
  logic [4:0]  wb_addr;
  logic [31:0] wb_data;
  logic [31:0] idex_instr, idex_a, idex_b, br_off;
  logic        br_taken;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dec_stage u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .ifid_instr_i(instr),
    .a_from_wb_i(a_wb), .b_from_wb_i(b_wb), .wb_we_i(wb_we),
    .wb_addr_i(wb_addr), .wb_data_i(wb_data),
    .idex_instr_o(idex_instr), .idex_a_o(idex_a), .idex_b_o(idex_b),
    .br_taken_o(br_taken), .br_offset_o(br_off)
  );

  function automatic logic [31:0] mk(input int opc, input int rs, input int rt, input int imm);
    return {6'(opc), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    stall = 0; instr = '0; a_wb = 0; b_wb = 0; wb_we = 0; wb_addr = '0; wb_data = '0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wb_we = 1; wb_addr = 5'(a); wb_data = d;
    @(negedge clk); idle();
  endtask

  task automatic rd(input int rs, input int rt, output logic [31:0] va, output logic [31:0] vb);
    instr = mk(0, rs, rt, 0);
    @(negedge clk); va = idex_a; vb = idex_b; idle();
  endtask

  task automatic t_reset();
    logic [31:0] a, b;
    chk("R1 instr", idex_instr, 0);
    chk("R1 a", idex_a, 0);
    chk("R1 b", idex_b, 0);
    chk("R1 taken", 32'(br_taken), 0);
    rd(5, 31, a, b);
    chk("R1 r5", a, 0);
    chk("R1 r31", b, 0);
  endtask

  task automatic t_write();
    logic [31:0] a, b;
    wr(4, 32'hA5A5_0001);
    wr(31, 32'hDEAD_BEEF);
    rd(4, 31, a, b);
    chk("R2 r4", a, 32'hA5A5_0001);
    chk("R2 r31", b, 32'hDEAD_BEEF);
  endtask

  task automatic t_r0();
    logic [31:0] a, b;
    wr(0, 32'hFFFF_FFFF);
    rd(0, 0, a, b);
    chk("R3 r0 a", a, 0);
    chk("R3 r0 b", b, 0);
  endtask

  task automatic t_pass();
    logic [31:0] w;
    w = mk(12, 4, 31, 16'h1234);
    instr = w;
    @(negedge clk);
    chk("R5 instr", idex_instr, w);
    chk("R5 a", idex_a, 32'hA5A5_0001);
    chk("R5 b", idex_b, 32'hDEAD_BEEF);
    idle();
  endtask

  task automatic t_bypass();
    logic [31:0] a, b;
    instr = mk(0, 6, 6, 0); wb_we = 1; wb_addr = 6; wb_data = 32'h0000_1234; a_wb = 1;
    @(negedge clk);
    chk("R4 a bypassed", idex_a, 32'h0000_1234);
    chk("R4 b not bypassed", idex_b, 0);
    idle();
    instr = mk(0, 4, 6, 0); wb_we = 1; wb_addr = 7; wb_data = 32'h55; b_wb = 1;
    @(negedge clk);
    chk("R4 b bypassed", idex_b, 32'h55);
    chk("R4 a from file", idex_a, 32'hA5A5_0001);
    idle();
    rd(6, 7, a, b);
    chk("R2 r6 after", a, 32'h1234);
  endtask

  task automatic t_stall();
    logic [31:0] a, b;
    wr(1, 5); wr(2, 5);
    stall = 1; instr = mk(48, 1, 2, 16'h0010);
    #1 chk("R7 stalled no take", 32'(br_taken), 0);
    chk("R8 offset zero", br_off, 0);
    @(negedge clk);
    chk("R6 instr", idex_instr, 0);
    chk("R6 a", idex_a, 0);
    chk("R6 b", idex_b, 0);
    idle();
    rd(2, 2, a, b);
    chk("R11 stalled rt kept", a, 5);
  endtask

  task automatic t_taken();
    logic [31:0] a, b, w;
    w = mk(48, 1, 2, 16'hFFF0);
    instr = w;
    #1 chk("R7 taken", 32'(br_taken), 1);
    chk("R8 offset neg", br_off, 32'hFFFF_FFF0);
    @(negedge clk);
    chk("R5 branch passes", idex_instr, w);
    idle();
    #1 chk("R7 idle", 32'(br_taken), 0);
    rd(2, 1, a, b);
    chk("R9 rt set", a, 1);
    chk("R9 rs kept", b, 5);
    wr(9, 9); wr(10, 9);
    instr = mk(48, 9, 10, 16'h0020);
    #1 chk("R8 offset pos", br_off, 32'h0000_0020);
    @(negedge clk); idle();
    rd(10, 0, a, b);
    chk("R9 rt set 2", a, 1);
    instr = mk(48, 0, 0, 16'h4);
    #1 chk("R7 r0 compare", 32'(br_taken), 1);
    @(negedge clk); idle();
    rd(0, 0, a, b);
    chk("R3 r0 branch", a, 0);
  endtask

  task automatic t_not_taken();
    logic [31:0] a, b;
    wr(3, 7);
    instr = mk(48, 1, 3, 16'h8);
    #1 chk("R11 unequal", 32'(br_taken), 0);
    chk("R8 unequal offset", br_off, 0);
    @(negedge clk); idle();
    rd(3, 0, a, b);
    chk("R11 rt kept", a, 7);
    wr(11, 3); wr(12, 3);
    instr = mk(47, 11, 12, 16'h8);
    #1 chk("R11 other opc", 32'(br_taken), 0);
    @(negedge clk); idle();
    rd(12, 0, a, b);
    chk("R11 other opc rt kept", a, 3);
  endtask

  task automatic t_collide();
    logic [31:0] a, b;
    // r1=5, r3=7; writeback r3<=5 with B bypass -> equal -> taken
    instr = mk(48, 1, 3, 16'h4); wb_we = 1; wb_addr = 3; wb_data = 5; b_wb = 1;
    #1 chk("R7 bypassed compare", 32'(br_taken), 1);
    @(negedge clk); idle();
    rd(3, 0, a, b);
    chk("R10 flag wins", a, 1);
    wr(13, 8); wr(14, 8);
    instr = mk(48, 13, 14, 16'h4); wb_we = 1; wb_addr = 20; wb_data = 32'h77;
    @(negedge clk); idle();
    rd(14, 20, a, b);
    chk("R10 flag other", a, 1);
    chk("R10 wb other", b, 32'h77);
  endtask

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_r0();
    t_pass();
    t_bypass();
    t_stall();
    t_taken();
    t_not_taken();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule